// File: doc/BRIEF.md
# HDLC Bit-Serial Receive Front End

This block takes a serial receive stream one bit at a time, on cycles where a bit strobe is high. It finds the frame delimiter, strips the zeros that a transmitter inserts for transparency, and builds characters least significant bit first. It also reports frame boundaries and a run of ones that aborts a frame. A separate hunt status shows when the block is searching for a delimiter and is not synchronised. Abort and hunt are kept as two independent status levels, and each one pulses a change strobe whenever it toggles, so an interrupt controller can latch every edge.

Reception runs only while the enable input is high. An optional mode turns the active-low carrier-detect input into a second enable. When address checking is on, the first character of each frame is compared with a programmed station address. All outputs are registered, so each one appears on the clock edge that follows the bit it reacts to.

Top module: `hdlc_rx_front`

## Requirements
- R1: After reset, hunt is 1, the abort status is 0 and every strobe (frame_start, frame_end, frame_abort, addr_match, data_valid, hunt_chg, abort_chg) is 0.
- R2: Hunt falls only after the last bit of a complete delimiter. The delimiter is the 8-bit pattern on flag_pattern, received LSB first; the default 0x7E arrives as 0,1,1,1,1,1,1,0. Every change of hunt is accompanied by hunt_chg for exactly one cycle.
- R3: Seven consecutive ones set the abort status and force hunt to 1 on the same edge.
- R4: The abort status clears on the next received zero, with abort_chg for one cycle. Hunt stays 1 until a complete delimiter ends, so the two clearing edges are separate.
- R5: An abort while a frame is open gives one frame_abort pulse, and the partly assembled character is not delivered on data_valid. An abort between frames gives no frame_abort.
- R6: Inside a frame, a zero that follows five consecutive ones is removed and does not enter any character.
- R7: Characters are built LSB first and appear on data_byte with a one-cycle data_valid. The first character after a delimiter also pulses frame_start.
- R8: A delimiter that ends while a frame is open pulses frame_end. A delimiter may share its leading zero with the closing zero of the one before it, and delimiters between frames produce no strobe.
- R9: With addr_search at 1, addr_match pulses with frame_start when the first character equals sec_addr. With addr_search at 0, or on a mismatch, it stays 0.
- R10: With auto_enable at 1 and dcd_n at 1, the receiver is off: hunt is forced to 1, abort is cleared, and received bits cause no strobe. With dcd_n at 0, reception proceeds.
- R11: With rx_enable at 0, the receiver is off in the same way, regardless of the bits received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one cycle for each received bit |
| rx_bit | input | 1 | Received serial bit |
| rx_enable | input | 1 | Receiver enable |
| auto_enable | input | 1 | Use carrier detect as a receive enable |
| dcd_n | input | 1 | Active-low carrier detect |
| addr_search | input | 1 | Compare the first character with sec_addr |
| flag_pattern | input | CHAR_W | Delimiter pattern, bit 0 received first |
| sec_addr | input | CHAR_W | Station address |
| hunt | output | 1 | Searching for a delimiter |
| abort_flag | output | 1 | Break/abort status |
| hunt_chg | output | 1 | One-cycle pulse on every change of hunt |
| abort_chg | output | 1 | One-cycle pulse on every change of abort_flag |
| frame_start | output | 1 | First character of a frame delivered |
| frame_end | output | 1 | Closing delimiter received |
| frame_abort | output | 1 | Open frame ended by an abort |
| addr_match | output | 1 | First character equals sec_addr |
| data_valid | output | 1 | data_byte holds a new character |
| data_byte | output | CHAR_W | Received character |

## Verification
The stream patterns are chosen to separate the decoding paths that could be confused with one another. A character of eight ones, and one with five ones followed by a data zero, check that only the inserted zero is removed. Delimiters that share a zero with the one before them must be recognised without any spurious strobe. A run of seven ones is sent both inside a frame and between frames, which tells frame_abort apart from a plain abort status. An idle line followed by a delimiter shows the abort status falling before hunt. Carrier-detect gating and the enable input are each checked by sending a full delimiter while the receiver is off and confirming that hunt does not move.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SYNC  = 2'd1,
    RX_FRAME = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hdlc_rx_window.sv
// Raw bit window and ones-run counter: finds delimiters, aborts and
// inserted zeros on the undeleted stream.
module hdlc_rx_window #(
  parameter int W         = 8,
  parameter int ABORT_RUN = 7,
  parameter int STUFF_RUN = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         bit_en,
  input  logic         rx_bit,
  input  logic [W-1:0] flag_pat,
  output logic         flag_hit,
  output logic         abort_hit,
  output logic         stuff_zero,
  output logic         run_over,
  output logic         zero_bit
);
  localparam int CW = $clog2(ABORT_RUN + 1);

  logic [W-1:0]  win_q, win_n;
  logic [CW-1:0] ones_q;

  always_comb begin
    win_n      = {rx_bit, win_q[W-1:1]};
    flag_hit   = bit_en && (win_n == flag_pat);
    abort_hit  = bit_en && rx_bit && (ones_q >= CW'(ABORT_RUN - 1));
    stuff_zero = bit_en && !rx_bit && (ones_q == CW'(STUFF_RUN));
    run_over   = bit_en && rx_bit && (ones_q >= CW'(STUFF_RUN));
    zero_bit   = bit_en && !rx_bit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q  <= '1;
      ones_q <= '0;
    end else if (bit_en) begin
      win_q <= win_n;
      if (!rx_bit)
        ones_q <= '0;
      else if (ones_q < CW'(ABORT_RUN))
        ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_assembler.sv
// Collects accepted data bits into LSB-first characters.
module hdlc_rx_assembler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         take,
  input  logic         rx_bit,
  output logic         char_done,
  output logic [W-1:0] char_val
);
  localparam int NW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [NW-1:0] cnt_q;

  always_comb begin
    char_val  = {rx_bit, sh_q[W-1:1]};
    char_done = take && (cnt_q == NW'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= char_val;
      cnt_q <= char_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_front.sv
module hdlc_rx_front
  import hdlc_rx_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int ABORT_RUN = 7,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              rx_enable,
  input  logic              auto_enable,
  input  logic              dcd_n,
  input  logic              addr_search,
  input  logic [CHAR_W-1:0] flag_pattern,
  input  logic [CHAR_W-1:0] sec_addr,
  output logic              hunt,
  output logic              abort_flag,
  output logic              hunt_chg,
  output logic              abort_chg,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_abort,
  output logic              addr_match,
  output logic              data_valid,
  output logic [CHAR_W-1:0] data_byte
);
  rx_state_e st_q, st_n;
  logic rx_on, bit_ok, asm_take, asm_clr;
  logic flag_hit, abort_hit, stuff_zero, run_over, zero_bit;
  logic char_done;
  logic [CHAR_W-1:0] char_val;
  logic abort_q, abort_n;
  logic start_n, end_n, fabort_n, match_n, dv_n;

  assign rx_on    = rx_enable && !(auto_enable && dcd_n);
  assign bit_ok   = bit_en && rx_on;
  assign asm_take = bit_ok && !stuff_zero && !run_over;

  hdlc_rx_window #(
    .W(CHAR_W), .ABORT_RUN(ABORT_RUN), .STUFF_RUN(STUFF_RUN)
  ) u_window (
    .clk(clk), .rst(rst), .clr(!rx_on), .bit_en(bit_ok), .rx_bit(rx_bit),
    .flag_pat(flag_pattern), .flag_hit(flag_hit), .abort_hit(abort_hit),
    .stuff_zero(stuff_zero), .run_over(run_over), .zero_bit(zero_bit)
  );

  hdlc_rx_assembler #(.W(CHAR_W)) u_asm (
    .clk(clk), .rst(rst), .clr(asm_clr), .take(asm_take), .rx_bit(rx_bit),
    .char_done(char_done), .char_val(char_val)
  );

  always_comb begin
    st_n     = st_q;
    abort_n  = abort_q;
    asm_clr  = 1'b0;
    start_n  = 1'b0;
    end_n    = 1'b0;
    fabort_n = 1'b0;
    match_n  = 1'b0;
    dv_n     = 1'b0;
    if (!rx_on) begin
      st_n    = RX_HUNT;
      abort_n = 1'b0;
      asm_clr = 1'b1;
    end else if (abort_hit) begin
      st_n     = RX_HUNT;
      abort_n  = 1'b1;
      asm_clr  = 1'b1;
      fabort_n = (st_q == RX_FRAME);
    end else begin
      if (zero_bit) abort_n = 1'b0;
      case (st_q)
        RX_HUNT: begin
          asm_clr = 1'b1;
          if (flag_hit) st_n = RX_SYNC;
        end
        RX_SYNC: begin
          if (flag_hit) begin
            asm_clr = 1'b1;
          end else if (char_done) begin
            start_n = 1'b1;
            dv_n    = 1'b1;
            match_n = addr_search && (char_val == sec_addr);
            st_n    = RX_FRAME;
          end
        end
        RX_FRAME: begin
          if (flag_hit) begin
            end_n   = 1'b1;
            asm_clr = 1'b1;
            st_n    = RX_SYNC;
          end else if (char_done) begin
            dv_n = 1'b1;
          end
        end
        default: st_n = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= RX_HUNT;
      abort_q     <= 1'b0;
      hunt_chg    <= 1'b0;
      abort_chg   <= 1'b0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      frame_abort <= 1'b0;
      addr_match  <= 1'b0;
      data_valid  <= 1'b0;
      data_byte   <= '0;
    end else begin
      st_q        <= st_n;
      abort_q     <= abort_n;
      hunt_chg    <= (st_n == RX_HUNT) != (st_q == RX_HUNT);
      abort_chg   <= abort_n != abort_q;
      frame_start <= start_n;
      frame_end   <= end_n;
      frame_abort <= fabort_n;
      addr_match  <= match_n;
      data_valid  <= dv_n;
      if (dv_n) data_byte <= char_val;
    end
  end

  assign hunt       = (st_q == RX_HUNT);
  assign abort_flag = abort_q;
endmodule

// File: rtl/hdlc_rx_front_chk.sv
module hdlc_rx_front_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic rx_bit,
  input logic rx_enable,
  input logic auto_enable,
  input logic dcd_n,
  input logic hunt,
  input logic abort_flag,
  input logic hunt_chg,
  input logic abort_chg,
  input logic frame_start,
  input logic frame_end,
  input logic frame_abort,
  input logic addr_match,
  input logic data_valid
);
  AST_HUNT_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
    hunt_chg == (hunt != $past(hunt))); // R2
  AST_ABORT_FORCES_HUNT: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> hunt); // R3
  AST_ABORT_CHG_PULSE: assert property (@(posedge clk) disable iff (rst)
    abort_chg == (abort_flag != $past(abort_flag))); // R4
  AST_ABORT_CLEARS_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (abort_flag && bit_en && !rx_bit) |=> !abort_flag); // R4
  AST_FRAME_ABORT_STATE: assert property (@(posedge clk) disable iff (rst)
    frame_abort |-> (hunt && abort_flag && !data_valid)); // R5
  AST_START_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (!hunt && data_valid)); // R7
  AST_ONE_FRAME_EVENT: assert property (@(posedge clk) disable iff (rst)
    $countones({frame_start, frame_end, frame_abort}) <= 1); // R8
  AST_MATCH_ON_START: assert property (@(posedge clk) disable iff (rst)
    addr_match |-> frame_start); // R9
  AST_CARRIER_GATE: assert property (@(posedge clk) disable iff (rst)
    (auto_enable && dcd_n) |=> (hunt && !abort_flag && !data_valid)); // R10
  AST_RX_OFF: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> (hunt && !abort_flag && !data_valid)); // R11
endmodule

bind hdlc_rx_front hdlc_rx_front_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
  .rx_enable(rx_enable), .auto_enable(auto_enable), .dcd_n(dcd_n),
  .hunt(hunt), .abort_flag(abort_flag), .hunt_chg(hunt_chg),
  .abort_chg(abort_chg), .frame_start(frame_start), .frame_end(frame_end),
  .frame_abort(frame_abort), .addr_match(addr_match), .data_valid(data_valid)
);

// File: tb/hdlc_rx_front_bench.sv
module hdlc_rx_front_bench;
  localparam int EV_FABORT = 0, EV_END = 1, EV_START = 2, EV_MATCH = 3,
                 EV_DATA = 4, EV_ACHG = 5, EV_HCHG = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, rx_bit = 1'b0, rx_enable = 1'b0;
  logic auto_enable = 1'b0, dcd_n = 1'b0, addr_search = 1'b1;
  logic [7:0] flag_pattern = 8'h7E, sec_addr = 8'hA5;
  logic hunt, abort_flag, hunt_chg, abort_chg, frame_start, frame_end;
  logic frame_abort, addr_match, data_valid;
  logic [7:0] data_byte;

  int n_cmp = 0, n_bad = 0, run = 0;
  bit done = 1'b0;
  int    q_kind[$];
  int    q_val[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  hdlc_rx_front u_hdlc_rx_front (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .rx_enable(rx_enable), .auto_enable(auto_enable), .dcd_n(dcd_n),
    .addr_search(addr_search), .flag_pattern(flag_pattern), .sec_addr(sec_addr),
    .hunt(hunt), .abort_flag(abort_flag), .hunt_chg(hunt_chg),
    .abort_chg(abort_chg), .frame_start(frame_start), .frame_end(frame_end),
    .frame_abort(frame_abort), .addr_match(addr_match),
    .data_valid(data_valid), .data_byte(data_byte)
  );

  task automatic expect_ev(input int kind, input int val, input string tag);
    q_kind.push_back(kind);
    q_val.push_back(val);
    q_tag.push_back(tag);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic observe(input int kind, input int val);
    n_cmp++;
    if (q_kind.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind %0d val %0h expected none", kind, val);
    end else begin
      int ek = q_kind.pop_front();
      int ev = q_val.pop_front();
      string et = q_tag.pop_front();
      if (ek != kind || ev != val) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d val %0h expected kind %0d val %0h",
                 et, kind, val, ek, ev);
      end
    end
  endtask

  // Monitor: fixed per-cycle order matches the order expectations are pushed
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (frame_abort) observe(EV_FABORT, 0);
      if (frame_end)   observe(EV_END, 0);
      if (frame_start) observe(EV_START, 0);
      if (addr_match)  observe(EV_MATCH, 0);
      if (data_valid)  observe(EV_DATA, int'(data_byte));
      if (abort_chg)   observe(EV_ACHG, int'(abort_flag));
      if (hunt_chg)    observe(EV_HCHG, int'(hunt));
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_raw(input logic [7:0] bits, input int n);
    for (int i = 0; i < n; i++) send_bit(bits[i]);
    run = 0;
  endtask

  task automatic send_flag();
    send_raw(8'h7E, 8);
  endtask

  // Transmitter-side zero insertion, written from R6
  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) begin
        run++;
        if (run == 5) begin
          send_bit(1'b0);
          run = 0;
        end
      end else begin
        run = 0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(hunt == 1'b1, "R1 hunt after reset", hunt, 1);
    check(abort_flag == 1'b0, "R1 abort after reset", abort_flag, 0);
    check({frame_start, frame_end, frame_abort, addr_match, data_valid,
           hunt_chg, abort_chg} == 7'b0, "R1 strobes after reset",
          {frame_start, frame_end, frame_abort, addr_match, data_valid,
           hunt_chg, abort_chg}, 0);

    rx_enable = 1'b1;
    @(negedge clk);
    // R3: idle ones in hunt raise abort on the seventh
    expect_ev(EV_ACHG, 1, "R3 abort on seventh one");
    send_raw(8'hFF, 7);
    check(abort_flag == 1'b1, "R3 abort level", abort_flag, 1);
    check(hunt == 1'b1, "R3 hunt during abort", hunt, 1);
    // R4: leading zero of the delimiter clears abort, hunt stays
    expect_ev(EV_ACHG, 0, "R4 abort clears on zero");
    send_raw(8'h00, 1);
    check(abort_flag == 1'b0, "R4 abort cleared", abort_flag, 0);
    check(hunt == 1'b1, "R4 hunt held after abort clears", hunt, 1);
    expect_ev(EV_HCHG, 0, "R2 hunt falls at delimiter end");
    send_raw(8'h3F, 7);
    check(hunt == 1'b0, "R2 hunt level", hunt, 0);

    // R7 R9 R6 R8: address match, zero deletion, close
    expect_ev(EV_START, 0, "R7 frame start");
    expect_ev(EV_MATCH, 0, "R9 address match");
    expect_ev(EV_DATA, 8'hA5, "R7 first char");
    send_byte(8'hA5);
    expect_ev(EV_DATA, 8'hFF, "R6 all-ones char");
    send_byte(8'hFF);
    expect_ev(EV_DATA, 8'h3E, "R6 five ones then data zero");
    send_byte(8'h3E);
    expect_ev(EV_END, 0, "R8 frame end");
    send_flag();

    // R9 mismatch; R8 shared-zero delimiter between frames
    expect_ev(EV_START, 0, "R7 second frame start");
    expect_ev(EV_DATA, 8'h12, "R9 mismatching address char");
    send_byte(8'h12);
    expect_ev(EV_DATA, 8'h55, "R7 alternating char");
    send_byte(8'h55);
    expect_ev(EV_END, 0, "R8 second frame end");
    send_flag();
    send_raw(8'h3F, 7);
    expect_ev(EV_START, 0, "R8 start after shared-zero delimiter");
    expect_ev(EV_DATA, 8'h81, "R8 char after shared zero");
    send_byte(8'h81);
    expect_ev(EV_END, 0, "R8 third frame end");
    send_flag();

    // R5: abort inside a frame, partial char dropped
    expect_ev(EV_START, 0, "R5 frame start before abort");
    expect_ev(EV_DATA, 8'h33, "R5 char before abort");
    send_byte(8'h33);
    send_raw(8'h00, 2);
    expect_ev(EV_FABORT, 0, "R5 frame abort");
    expect_ev(EV_ACHG, 1, "R3 abort rises in frame");
    expect_ev(EV_HCHG, 1, "R3 hunt forced by abort");
    send_raw(8'hFF, 7);
    expect_ev(EV_ACHG, 0, "R4 abort clears");
    send_raw(8'h00, 1);
    check(hunt == 1'b1, "R4 hunt still set", hunt, 1);
    expect_ev(EV_HCHG, 0, "R4 hunt clears on delimiter");
    send_raw(8'h3F, 7);

    // R5: abort between frames gives no frame_abort
    expect_ev(EV_ACHG, 1, "R5 abort between frames");
    expect_ev(EV_HCHG, 1, "R5 hunt between frames");
    send_raw(8'hFF, 7);
    expect_ev(EV_ACHG, 0, "R4 abort clears again");
    send_raw(8'h00, 1);
    expect_ev(EV_HCHG, 0, "R2 resync");
    send_flag();

    // R10: carrier-detect gating
    expect_ev(EV_HCHG, 1, "R10 carrier loss forces hunt");
    @(negedge clk);
    auto_enable = 1'b1;
    dcd_n = 1'b1;
    repeat (2) @(negedge clk);
    send_flag();
    check(hunt == 1'b1, "R10 delimiter ignored while gated", hunt, 1);
    dcd_n = 1'b0;
    @(negedge clk);
    expect_ev(EV_HCHG, 0, "R10 sync with carrier present");
    send_flag();
    addr_search = 1'b0;
    expect_ev(EV_START, 0, "R9 start with search off");
    expect_ev(EV_DATA, 8'hA5, "R9 no match with search off");
    send_byte(8'hA5);
    expect_ev(EV_END, 0, "R8 end with carrier");
    send_flag();

    // R11: receiver disabled
    expect_ev(EV_HCHG, 1, "R11 disable forces hunt");
    @(negedge clk);
    rx_enable = 1'b0;
    repeat (2) @(negedge clk);
    send_flag();
    send_byte(8'h42);
    check(hunt == 1'b1, "R11 input ignored while disabled", hunt, 1);
    check(abort_flag == 1'b0, "R11 abort clear while disabled", abort_flag, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    check(q_kind.size() == 0, "missing expected events", q_kind.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule